// File: doc/BRIEF.md
# System Control Flag Latch

This block keeps eight one-bit control flags for the rest of the system. Software changes a flag by writing to an address, not by sending data. Address bits 3..1 pick the flag. Address bit 4 is the level that flag takes. Every flag therefore has two write addresses 0x10 apart: one clears it and one sets it. The block has no data input, so the value on the data bus has no effect. Upstream logic decodes the region (base 0x3A0000, decode mask 0xFE0001) into a single select. The block only sees that select, the write strobe, an odd-byte lane indication and address bits 4..1.

A small two-state controller handles each qualifying write.
- In `ST_IDLE` the block waits.
- A qualifying write moves it to `ST_COMMIT` and stores the flag index and level. This is the transition IDLE→COMMIT.
- In `ST_COMMIT` the stored update goes into the flag bank at the next clock edge.
- Another qualifying write in the same cycle keeps it in `ST_COMMIT` (COMMIT→COMMIT).
- Otherwise it returns to idle (COMMIT→IDLE).
- With no write it stays idle (IDLE→IDLE).

The flags drive video darkening, vector-table source, two memory-card write lines of opposite sense, card register select, fix/sound ROM source, backup RAM protection and palette bank.

Top module: `sysctl_addr_latch`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears all eight flags to 0, and the controller returns to ST_IDLE.
- R2: A write qualifies only when sel_i, wr_i and odd_lane_i are all 1 at a rising edge. If any of them is 0, no flag changes.
- R3: offs_i[2:0] (address bits 3..1) selects the flag:
  - 0 → shadow_o
  - 1 → vec_swap_o
  - 2 → card_lock_a_o
  - 3 → card_unlock_b_o
  - 4 → card_regsel_n_o
  - 5 → rom_cart_o
  - 6 → sram_unlock_o
  - 7 → pal_bank0_o
- R4: The selected flag takes the value of offs_i[3] (address bit 4). The block has no data bus input.
- R5: A qualifying write changes only the addressed flag. The other seven keep their values.
- R6: A write sampled at edge N shows at the outputs after edge N+1. Writes on back-to-back cycles are each applied, one per cycle, in issue order.
- R7: The flag polarities, by byte offset within the region, are:
  - 0x01 → shadow_o=0 (normal video); 0x11 → shadow_o=1 (darkened)
  - 0x05 → card_lock_a_o=0 (card writes enabled); 0x15 → card_lock_a_o=1 (disabled)
  - 0x07 → card_unlock_b_o=0 (disabled); 0x17 → card_unlock_b_o=1 (enabled)
  - 0x0F → pal_bank0_o=0 (bank 1); 0x1F → pal_bank0_o=1 (bank 0)
  - 0x0B → rom_cart_o=0 (embedded ROMs); 0x1B → rom_cart_o=1 (cartridge ROMs)
  - 0x0D → sram_unlock_o=0 (RAM protected); 0x1D → sram_unlock_o=1 (unprotected)
- R8: The controller moves IDLE→COMMIT on a qualifying write and stays in COMMIT while writes continue. It goes COMMIT→IDLE when no write qualifies. It holds IDLE when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Decoded region select |
| wr_i | input | 1 | Write strobe |
| odd_lane_i | input | 1 | Odd byte lane active (address bit 0 = 1) |
| offs_i | input | 4 | Address bits 4..1: bit 3 = level, bits 2..0 = flag index |
| shadow_o | output | 1 | 1 = darkened video |
| vec_swap_o | output | 1 | 1 = cartridge vector table |
| card_lock_a_o | output | 1 | 1 = card writes disabled (line A) |
| card_unlock_b_o | output | 1 | 1 = card writes enabled (line B) |
| card_regsel_n_o | output | 1 | 0 = card register select active |
| rom_cart_o | output | 1 | 1 = cartridge fix/sound ROMs |
| sram_unlock_o | output | 1 | 1 = backup RAM writable |
| pal_bank0_o | output | 1 | 1 = palette bank 0 |

## Verification
A wrong stored index or level in the controller shows one cycle after the write completes. It appears as the wrong output toggling, or as a second output changing together with the intended one. A dropped commit leaves an output stuck at its old level. That fault shows at the first check after the write, and the back-to-back and same-flag sequences also expose any reordering. A gating fault on the select, strobe or lane shows as a flag changing two edges after a write that should not have qualified.

// File: rtl/sal_pkg.sv
package sal_pkg;
    localparam int IDX_W  = 3;
    localparam int FLAG_N = 1 << IDX_W;
    localparam int OFFS_W = IDX_W + 1;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } wr_state_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             val;
    } flag_upd_t;

    localparam int F_SHADOW   = 0;
    localparam int F_VECSWAP  = 1;
    localparam int F_CARD_A   = 2;
    localparam int F_CARD_B   = 3;
    localparam int F_REGSEL_N = 4;
    localparam int F_ROMCART  = 5;
    localparam int F_SRAM     = 6;
    localparam int F_PAL0     = 7;
endpackage

// File: rtl/sal_wr_qualify.sv
module sal_wr_qualify
    import sal_pkg::*;
(
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic              odd_lane_i,
    input  logic [OFFS_W-1:0] offs_i,
    output logic              hit_o,
    output flag_upd_t         upd_o
);
    // R2: all three qualifiers must be present
    always_comb begin
        hit_o     = sel_i & wr_i & odd_lane_i;
        // R3 / R4: low bits pick the flag, top bit is the level
        upd_o.idx = offs_i[IDX_W-1:0];
        upd_o.val = offs_i[IDX_W];
    end
endmodule

// File: rtl/sal_wr_fsm.sv
module sal_wr_fsm
    import sal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit_i,
    input  flag_upd_t upd_i,
    output logic      commit_o,
    output flag_upd_t upd_o
);
    wr_state_e state_q, state_d;
    flag_upd_t pend_q;

    // R8: next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = hit_i ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_d = hit_i ? ST_COMMIT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            if (hit_i)
                pend_q <= upd_i;
        end
    end

    // Output process
    always_comb begin
        commit_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   commit_o = 1'b0;
            ST_COMMIT: commit_o = 1'b1;
            default:   commit_o = 1'b0;
        endcase
        upd_o = pend_q;
    end
endmodule

// File: rtl/sal_flag_bank.sv
module sal_flag_bank
    import sal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  flag_upd_t         upd_i,
    output logic [FLAG_N-1:0] flags_o
);
    for (genvar gi = 0; gi < FLAG_N; gi++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags_o[gi] <= 1'b0;               // R1
            else if (commit_i && (upd_i.idx == IDX_W'(gi)))
                flags_o[gi] <= upd_i.val;          // R5: only the addressed flag
        end
    end
endmodule

// File: rtl/sysctl_addr_latch.sv
module sysctl_addr_latch
    import sal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic              odd_lane_i,
    input  logic [OFFS_W-1:0] offs_i,
    output logic              shadow_o,
    output logic              vec_swap_o,
    output logic              card_lock_a_o,
    output logic              card_unlock_b_o,
    output logic              card_regsel_n_o,
    output logic              rom_cart_o,
    output logic              sram_unlock_o,
    output logic              pal_bank0_o
);
    logic              hit;
    flag_upd_t         upd_raw;
    flag_upd_t         upd_pend;
    logic              commit;
    logic [FLAG_N-1:0] flags;

    sal_wr_qualify u_qual (
        .sel_i      (sel_i),
        .wr_i       (wr_i),
        .odd_lane_i (odd_lane_i),
        .offs_i     (offs_i),
        .hit_o      (hit),
        .upd_o      (upd_raw)
    );

    sal_wr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit),
        .upd_i    (upd_raw),
        .commit_o (commit),
        .upd_o    (upd_pend)
    );

    sal_flag_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .upd_i    (upd_pend),
        .flags_o  (flags)
    );

    always_comb begin
        shadow_o        = flags[F_SHADOW];
        vec_swap_o      = flags[F_VECSWAP];
        card_lock_a_o   = flags[F_CARD_A];
        card_unlock_b_o = flags[F_CARD_B];
        card_regsel_n_o = flags[F_REGSEL_N];
        rom_cart_o      = flags[F_ROMCART];
        sram_unlock_o   = flags[F_SRAM];
        pal_bank0_o     = flags[F_PAL0];
    end
endmodule

// File: rtl/sysctl_addr_latch_chk.sv
module sysctl_addr_latch_chk
    import sal_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sel_i,
    input logic              wr_i,
    input logic              odd_lane_i,
    input logic [OFFS_W-1:0] offs_i,
    input logic              shadow_o,
    input logic              vec_swap_o,
    input logic              card_lock_a_o,
    input logic              card_unlock_b_o,
    input logic              card_regsel_n_o,
    input logic              rom_cart_o,
    input logic              sram_unlock_o,
    input logic              pal_bank0_o
);
    logic [FLAG_N-1:0] fv;
    logic              qual;

    always_comb begin
        fv = {pal_bank0_o, sram_unlock_o, rom_cart_o, card_regsel_n_o,
              card_unlock_b_o, card_lock_a_o, vec_swap_o, shadow_o};
        qual = sel_i & wr_i & odd_lane_i;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (fv == '0); // R1
        end
    end

    AST_NO_QUAL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !qual |=> ##1 $stable(fv)); // R2

    AST_LEVEL_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> ##1 (fv[$past(offs_i[IDX_W-1:0], 2)] == $past(offs_i[IDX_W], 2))); // R4

    AST_SINGLE_FLAG_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ($countones(fv ^ $past(fv)) <= 1)); // R5

    AST_NO_EARLY_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (qual && !$past(qual)) |=> $stable(fv)); // R6
endmodule

bind sysctl_addr_latch sysctl_addr_latch_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .sel_i           (sel_i),
    .wr_i            (wr_i),
    .odd_lane_i      (odd_lane_i),
    .offs_i          (offs_i),
    .shadow_o        (shadow_o),
    .vec_swap_o      (vec_swap_o),
    .card_lock_a_o   (card_lock_a_o),
    .card_unlock_b_o (card_unlock_b_o),
    .card_regsel_n_o (card_regsel_n_o),
    .rom_cart_o      (rom_cart_o),
    .sram_unlock_o   (sram_unlock_o),
    .pal_bank0_o     (pal_bank0_o)
);

// File: tb/sysctl_addr_latch_tb.sv
module sysctl_addr_latch_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_i = 1'b0;
    logic       wr_i = 1'b0;
    logic       odd_lane_i = 1'b0;
    logic [3:0] offs_i = 4'h0;
    logic       shadow_o, vec_swap_o, card_lock_a_o, card_unlock_b_o;
    logic       card_regsel_n_o, rom_cart_o, sram_unlock_o, pal_bank0_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sysctl_addr_latch u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .sel_i           (sel_i),
        .wr_i            (wr_i),
        .odd_lane_i      (odd_lane_i),
        .offs_i          (offs_i),
        .shadow_o        (shadow_o),
        .vec_swap_o      (vec_swap_o),
        .card_lock_a_o   (card_lock_a_o),
        .card_unlock_b_o (card_unlock_b_o),
        .card_regsel_n_o (card_regsel_n_o),
        .rom_cart_o      (rom_cart_o),
        .sram_unlock_o   (sram_unlock_o),
        .pal_bank0_o     (pal_bank0_o)
    );

    // Fields: sel, wr, odd, offs[3:0] (address bits 4..1), pad, expected flags[7:0]
    localparam int NV = 16;
    localparam logic [15:0] VEC [NV] = '{
        {3'b111, 4'b1000, 1'b0, 8'h01},  // 0x11 shadow set       R7
        {3'b111, 4'b1111, 1'b0, 8'h81},  // 0x1F palette bank 0   R7
        {3'b111, 4'b0010, 1'b0, 8'h81},  // 0x05 card A enabled   R7
        {3'b111, 4'b1010, 1'b0, 8'h85},  // 0x15 card A disabled  R7
        {3'b111, 4'b1011, 1'b0, 8'h8D},  // 0x17 card B enabled   R7
        {3'b111, 4'b1101, 1'b0, 8'hAD},  // 0x1B cartridge ROMs   R3
        {3'b011, 4'b1001, 1'b0, 8'hAD},  // no select             R2
        {3'b101, 4'b1001, 1'b0, 8'hAD},  // no strobe             R2
        {3'b110, 4'b1001, 1'b0, 8'hAD},  // even lane             R2
        {3'b111, 4'b1001, 1'b0, 8'hAF},  // 0x13 vector swap      R3
        {3'b111, 4'b0000, 1'b0, 8'hAE},  // 0x01 shadow clear     R4
        {3'b111, 4'b0111, 1'b0, 8'h2E},  // 0x0F palette bank 1   R7
        {3'b111, 4'b1110, 1'b0, 8'h6E},  // 0x1D RAM unprotected  R7
        {3'b111, 4'b1100, 1'b0, 8'h7E},  // 0x19 regsel off       R3
        {3'b111, 4'b0011, 1'b0, 8'h76},  // 0x07 card B disabled  R5
        {3'b111, 4'b0110, 1'b0, 8'h36}   // 0x0D RAM protected    R5
    };

    function automatic logic [7:0] flags_now();
        return {pal_bank0_o, sram_unlock_o, rom_cart_o, card_regsel_n_o,
                card_unlock_b_o, card_lock_a_o, vec_swap_o, shadow_o};
    endfunction

    task automatic check(input logic [7:0] exp, input string req);
        checks++;
        if (flags_now() !== exp) begin
            errors++;
            $display("FAIL %s: flags=%02h expected=%02h", req, flags_now(), exp);
        end
    endtask

    task automatic drive(input logic s, input logic w, input logic o, input logic [3:0] a);
        sel_i = s; wr_i = w; odd_lane_i = o; offs_i = a;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: flags=%02h expected=completion", flags_now());
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(8'h00, "R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check(8'h00, "R1 after release");

        // Table walk: apply, deassert, check after the second edge (R6)
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12:9]);
            @(negedge clk);
            drive(1'b0, 1'b0, 1'b0, 4'h0);
            @(negedge clk);
            check(VEC[i][7:0], $sformatf("R2/R3/R4/R5/R7 vector %0d", i));
        end

        // Back-to-back writes to different flags: 0x03 then 0x11
        drive(1'b1, 1'b1, 1'b1, 4'b0001);
        @(negedge clk);
        check(8'h36, "R6 no change one edge after write");
        drive(1'b1, 1'b1, 1'b1, 4'b1000);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 4'h0);
        check(8'h34, "R6 first of pair applied");
        @(negedge clk);
        check(8'h35, "R6 second of pair applied");

        // Same flag twice: 0x1F then 0x0F, last one wins (R8 stays in COMMIT)
        drive(1'b1, 1'b1, 1'b1, 4'b1111);
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b1, 4'b0111);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 4'h0);
        check(8'hB5, "R8 intermediate level");
        @(negedge clk);
        check(8'h35, "R8 issue order kept");
        @(negedge clk);
        check(8'h35, "R8 idle holds flags");

        // Reset in the middle of activity
        drive(1'b1, 1'b1, 1'b1, 4'b1111);
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 4'h0);
        #1;
        check(8'h00, "R1 async reset clears");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(8'h00, "R1 pending write discarded");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule